// File: doc/BRIEF.md
# Two-Bank Alternating Stream Buffer

This block buffers a word stream in two equal banks. Each bank is a small first-in first-out store. At any time one bank takes incoming words and the other bank gives words out. When the filling bank has no free entry left and the draining bank has run dry, the two banks swap roles. The full bank then drains while the empty one fills. Because of this, a producer and a consumer can both move one word per clock for as long as their rates match. The two roles never share a bank.

Words pass through whole banks, so a word is not visible at the output until its bank has filled. A producer that stops partway through a bank leaves those words held until enough further words arrive to fill it. The input takes a word when `wr_valid` is high and `wr_full` is low, so `wr_full` serves as the inverse of a ready signal. The output offers a word when `rd_valid` is high and hands it over when `rd_ready` is also high. While `rd_valid` is high and `rd_ready` is low, `rd_data` holds its value. Word width and bank depth are parameters. Everything runs on one clock.

Top module: `pp_fifo_pair`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) empties both banks and gives bank 0 the filling role. Right after reset, `rd_empty` is 1, `rd_valid` is 0 and `wr_full` is 0.
- R2: A word is taken exactly in the cycles where `wr_valid` is 1 and `wr_full` is 0. It is stored in the bank that holds the filling role in that cycle.
- R3: A write offered while `wr_full` is 1 is dropped. No bank changes, and the dropped word never appears at the output.
- R4: A read requested while `rd_empty` is 1 has no effect. The next word delivered is still the oldest word not yet delivered.
- R5: Words leave in exactly the order they were taken, each one exactly once, across any number of role swaps.
- R6: When the filling bank holds DEPTH words and the draining bank holds none, the roles swap in that same cycle. The oldest word of the full bank is presented on `rd_data` with `rd_valid` high, and a write in that cycle goes into the other bank.
- R7: `wr_full` is 1 exactly when the filling bank holds DEPTH words and the draining bank holds at least one word.
- R8: `rd_empty` is 1 exactly when the draining bank holds no word and the filling bank holds fewer than DEPTH words, so words in a partly filled bank cannot be read. `rd_valid` is always the inverse of `rd_empty`.
- R9: A write and a read can both complete in the same cycle. Under sustained traffic on both sides, one word moves in and one moves out every cycle, including the cycles in which the roles swap.
- R10: In any cycle at most one bank is written and at most one bank is read, and no bank is written and read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Producer offers `wr_data` |
| wr_data | input | WIDTH | Word offered for storage |
| wr_full | output | 1 | Offered word will not be taken (inverse of ready) |
| rd_valid | output | 1 | `rd_data` holds a deliverable word |
| rd_ready | input | 1 | Consumer takes the word when `rd_valid` is high |
| rd_data | output | WIDTH | Oldest undelivered word |
| rd_empty | output | 1 | No word can be delivered this cycle |

## Verification
The assertions assume that `rst` is high during the first clock edge. They also assume that a request on either side is just a level sampled at the edge, with no need for it to be held until it is accepted. The stimulus therefore opens with reset and then drives its inputs only at falling edges. It deliberately raises `wr_valid` against a full buffer and `rd_ready` against an empty one, so the properties about ignored requests are exercised rather than left idle. Word values come from a counter, with a distinct marker used for refused writes. This lets any reordering, duplication or leak of a refused word show up in the output sequence.

// File: rtl/pp_fifo_pkg.sv
package pp_fifo_pkg;
  localparam int NUM_BANKS = 2;
  typedef logic bank_id_t;
  localparam bank_id_t BANK_RESET = 1'b0;
endpackage

// File: rtl/pp_bank.sv
module pp_bank #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (we) mem[wptr_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      rptr_q <= '0;
      count  <= '0;
    end else begin
      if (we) wptr_q <= bump(wptr_q);
      if (re) rptr_q <= bump(rptr_q);
      case ({we, re})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rptr_q];
endmodule

// File: rtl/pp_role_ctrl.sv
module pp_role_ctrl
  import pp_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt0,
  input  logic [CW-1:0] cnt1,
  output bank_id_t      role_q,
  output bank_id_t      wr_bank,
  output logic          wr_full,
  output logic          rd_empty
);
  logic [CW-1:0] fill_cnt, drain_cnt;
  logic          fill_done, drain_dry, swap_now;

  assign fill_cnt  = role_q ? cnt1 : cnt0;
  assign drain_cnt = role_q ? cnt0 : cnt1;
  assign fill_done = (fill_cnt == CW'(DEPTH));
  assign drain_dry = (drain_cnt == '0);
  assign swap_now  = fill_done && drain_dry;

  assign wr_bank  = role_q ^ swap_now;
  assign wr_full  = fill_done && !drain_dry;
  assign rd_empty = drain_dry && !fill_done;

  always_ff @(posedge clk) begin
    if (rst) role_q <= BANK_RESET;
    else     role_q <= wr_bank;
  end
endmodule

// File: rtl/pp_fifo_pair.sv
module pp_fifo_pair
  import pp_fifo_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_full,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_empty
);
  logic [CW-1:0]        bank_cnt   [NUM_BANKS];
  logic [WIDTH-1:0]     bank_rdata [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_we, bank_re;
  bank_id_t             role_q, wr_bank;
  logic                 wr_fire, rd_fire;

  pp_role_ctrl #(.DEPTH(DEPTH)) u_role (
    .clk      (clk),
    .rst      (rst),
    .cnt0     (bank_cnt[0]),
    .cnt1     (bank_cnt[1]),
    .role_q   (role_q),
    .wr_bank  (wr_bank),
    .wr_full  (wr_full),
    .rd_empty (rd_empty)
  );

  assign wr_fire  = wr_valid && !wr_full;
  assign rd_valid = !rd_empty;
  assign rd_fire  = rd_ready && rd_valid;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_we[b] = wr_fire && (wr_bank == bank_id_t'(b));
    assign bank_re[b] = rd_fire && (wr_bank != bank_id_t'(b));
    pp_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (bank_we[b]),
      .wdata (wr_data),
      .re    (bank_re[b]),
      .rdata (bank_rdata[b]),
      .count (bank_cnt[b])
    );
  end

  assign rd_data = bank_rdata[~wr_bank];
endmodule

// File: rtl/pp_fifo_pair_chk.sv
module pp_fifo_pair_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_valid,
  input logic          wr_full,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic          rd_empty,
  input logic          role,
  input logic [CW-1:0] cnt0,
  input logic [CW-1:0] cnt1,
  input logic [1:0]    we,
  input logic [1:0]    re
);
  logic [CW-1:0] fill_c, drain_c;
  logic          turn;
  assign fill_c  = role ? cnt1 : cnt0;
  assign drain_c = role ? cnt0 : cnt1;
  assign turn    = (fill_c == CW'(DEPTH)) && (drain_c == '0);

  p_reset_clean_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt0 == '0 && cnt1 == '0 && role == 1'b0));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt0 <= CW'(DEPTH)) && (cnt1 <= CW'(DEPTH)));

  p_full_refuses_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_full && wr_valid && !(rd_valid && rd_ready)) |=> ($stable(cnt0) && $stable(cnt1)));

  p_empty_ignores_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_empty && rd_ready && !(wr_valid && !wr_full)) |=> ($stable(cnt0) && $stable(cnt1)));

  p_swap_taken_r6: assert property (@(posedge clk) disable iff (rst)
    turn |=> (role != $past(role)));

  p_role_held_r6: assert property (@(posedge clk) disable iff (rst)
    !turn |=> $stable(role));

  p_empty_flag_r8: assert property (@(posedge clk) disable iff (rst)
    rd_empty |-> (drain_c == '0 && fill_c != CW'(DEPTH)));

  p_exclusive_banks_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we) && $onehot0(re) && ((we & re) == 2'b00));
endmodule

bind pp_fifo_pair pp_fifo_pair_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_valid (wr_valid),
  .wr_full  (wr_full),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_empty (rd_empty),
  .role     (role_q),
  .cnt0     (bank_cnt[0]),
  .cnt1     (bank_cnt[1]),
  .we       (bank_we),
  .re       (bank_re)
);

// File: tb/pp_fifo_pair_tb_top.sv
module pp_fifo_pair_tb_top;
  localparam int W = 8;
  localparam int D = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_valid = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         rd_ready = 1'b0;
  logic         wr_full, rd_valid, rd_empty;
  logic [W-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference model built from the requirements
  int           m_fill, m_drain;
  logic [W-1:0] exp_q [$];
  logic [W-1:0] seq = 8'h01;
  bit           last_wr_ok, last_rd_ok;

  always #10 clk = ~clk;

  pp_fifo_pair #(.WIDTH(W), .DEPTH(D)) dut_i (
    .clk (clk), .rst (rst),
    .wr_valid (wr_valid), .wr_data (wr_data), .wr_full (wr_full),
    .rd_valid (rd_valid), .rd_ready (rd_ready), .rd_data (rd_data),
    .rd_empty (rd_empty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle: drive at the falling edge, compare settled outputs, update model
  task automatic step(input bit wv, input logic [W-1:0] wd, input bit rr);
    bit swapped, e_full, e_empty;
    @(negedge clk);
    wr_valid = wv; wr_data = wd; rd_ready = rr;
    #1;
    swapped = (m_fill == D) && (m_drain == 0);
    if (swapped) begin m_drain = D; m_fill = 0; end
    e_full  = (m_fill == D);
    e_empty = (m_drain == 0);
    check(wr_full == e_full, "R7", wr_full, e_full);
    check(rd_empty == e_empty, "R8", rd_empty, e_empty);
    check(rd_valid == !e_empty, "R8", rd_valid, !e_empty);
    if (!e_empty)
      check(rd_data == exp_q[0], swapped ? "R6" : "R5", rd_data, exp_q[0]);
    last_wr_ok = wv && !e_full;
    last_rd_ok = rr && !e_empty;
    if (last_wr_ok) begin exp_q.push_back(wd); m_fill++; end
    if (last_rd_ok) begin void'(exp_q.pop_front()); m_drain--; end
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0);
  endtask

  task automatic push_word();
    step(1'b1, seq, 1'b0);
    seq++;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; wr_valid = 1'b0; rd_ready = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_fill = 0; m_drain = 0; exp_q.delete();
    #1;
    check(rd_empty == 1'b1, "R1", rd_empty, 1);
    check(rd_valid == 1'b0, "R1", rd_valid, 0);
    check(wr_full == 1'b0, "R1", wr_full, 0);
  endtask

  // R8: a partly filled bank stays hidden; R6: the word that fills it swaps at once
  task automatic t_partial_hidden();
    t_reset();
    for (int i = 0; i < D - 1; i++) push_word();
    idle();
    check(rd_empty == 1'b1, "R8", rd_empty, 1);
    push_word();
    check(last_wr_ok, "R2", last_wr_ok, 1);
    idle();
    check(rd_valid == 1'b1, "R6", rd_valid, 1);
    for (int i = 0; i < D; i++) step(1'b0, '0, 1'b1);
    idle();
    check(exp_q.size() == 0, "R5", exp_q.size(), 0);
  endtask

  // R3/R7: refused writes against a full pair must never reach the output
  task automatic t_overflow();
    int delivered = 0;
    t_reset();
    for (int i = 0; i < 2 * D; i++) push_word();
    idle();
    check(wr_full == 1'b1, "R7", wr_full, 1);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 8'hEE, 1'b0);
      check(!last_wr_ok, "R3", last_wr_ok, 0);
    end
    for (int i = 0; i < 3 * D; i++) begin
      step(1'b0, '0, 1'b1);
      if (last_rd_ok) begin
        delivered++;
        check(rd_data != 8'hEE, "R3", rd_data, 0);
      end
    end
    check(delivered == 2 * D, "R3", delivered, 2 * D);
    check(rd_empty == 1'b1, "R4", rd_empty, 1);
  endtask

  // R4: read requests against an empty pair change nothing
  task automatic t_underflow();
    t_reset();
    for (int i = 0; i < 5; i++) step(1'b0, '0, 1'b1);
    for (int i = 0; i < D; i++) push_word();
    idle();
    check(rd_valid == 1'b1, "R4", rd_valid, 1);
    for (int i = 0; i < D; i++) step(1'b0, '0, 1'b1);
  endtask

  // R9/R10: both sides busy every cycle; order check would expose a shared bank
  task automatic t_stream();
    int both = 0;
    t_reset();
    for (int i = 0; i < D; i++) push_word();
    for (int i = 0; i < 40; i++) begin
      step(1'b1, seq, 1'b1);
      if (last_wr_ok) seq++;
      if (last_wr_ok && last_rd_ok) both++;
    end
    check(both == 40, "R9", both, 40);
    for (int i = 0; i < 3 * D; i++) step(1'b0, '0, 1'b1);
  endtask

  // R1: reset in the middle of traffic discards everything
  task automatic t_reset_mid();
    for (int i = 0; i < D + 2; i++) push_word();
    t_reset();
    idle();
    check(rd_empty == 1'b1, "R1", rd_empty, 1);
    for (int i = 0; i < D; i++) push_word();
    idle();
    check(rd_valid == 1'b1, "R1", rd_valid, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_partial_hidden();
    t_overflow();
    t_underflow();
    t_stream();
    t_reset_mid();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end
endmodule